// File: doc/BRIEF.md
# Video RAM Block-Copy Controller

This block copies data from anywhere in the 16-bit address space, except the video RAM window itself, into the 8 KiB video RAM window at 0x8000-0x9FFF. Software programs a source address, a destination address and a control byte through a small byte-wide configuration port. Both addresses are aligned down to 16 bytes. The control byte picks one of two modes. In burst mode the whole length moves at once. In line-gap mode one 16-byte chunk moves each time the horizontal-blank strobe rises. The CPU is stalled while any copy runs.

The block drives a byte-wide read port toward the source memory and a byte-wide write port toward video RAM. Read data comes back one cycle after the read is issued. When a copy finishes, the block writes the final source and destination back into the address registers. It also updates a status byte. In line-gap mode the status byte counts the remaining chunks down. It reads 0xFF once all chunks are done.

Top module: `vram_dma_ctrl`

## Requirements
- R1: The source address is {source-high register, source-low register} with bits 3:0 forced to zero. Each copy reads the source bytes in ascending address order.
- R2: A control write whose assembled source lies in 0x8000-0x9FFF starts no copy and leaves the mode unchanged. The status byte then reads the written value with bit 7 set.
- R3: The destination is 0x8000 OR ({destination-high, destination-low} AND 0x1FF0). When the destination steps past 0x9FFF it wraps to 0x8000.
- R4: A control write with bit 7 clear, while line-gap mode is inactive, starts a burst copy at once. The burst length is (bits 6:0 + 1) x 16 bytes. Once the copy ends, the status byte reads 0xFF.
- R5: A control write with bit 7 set enables line-gap mode. If the video mode input is 0, one 16-byte chunk starts at once. Otherwise the write only arms the mode, and the status byte reads the written bits 6:0 with bit 7 clear. A later control write with bit 7 clear and a nonzero video mode cancels line-gap mode without copying anything.
- R6: Each byte takes two cycles. In the first cycle the read is issued. In the next cycle the returned data is written. The CPU stall output is high for exactly 2 x length cycles per copy.
- R7: When a copy finishes, the four address registers hold the next source and destination, including the destination wrap.
- R8: In line-gap mode the status byte is decremented after each chunk. When the decrement takes the status byte to 0xFF, line-gap mode ends.
- R9: While line-gap mode is active, each rising edge of the horizontal-blank input starts exactly one 16-byte chunk. Holding the input high starts nothing more.
- R10: A write that enables line-gap mode while the display-enable input is low, and does not start a chunk, sets the status byte to 0x80 OR ((value + 1) AND 0x7F).
- R11: The read-back select codes are 0 = source high, 1 = source low, 2 = destination high, 3 = destination low, 4 = status. After reset, the four address registers read 0x00, the status byte reads 0xFF and the stall output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe; ignored while a copy runs |
| cfg_sel | input | 3 | Register select for writes (codes as in R11) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rsel | input | 3 | Register select for read-back |
| cfg_rdata | output | 8 | Read-back data (0xFF for unused codes) |
| lcd_mode | input | 2 | Current video mode; 0 means horizontal blank |
| lcd_on | input | 1 | Display enabled |
| hblank | input | 1 | Horizontal-blank strobe |
| mem_rd_en | output | 1 | Source read request |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Source data, valid the cycle after the request |
| mem_wr_en | output | 1 | Video RAM write strobe |
| mem_wr_addr | output | 16 | Video RAM write address |
| mem_wr_data | output | 8 | Video RAM write data |
| cpu_stall | output | 1 | Holds the CPU while a copy runs |

## Verification
The hardest state to reach is line-gap mode armed with the display off. The status byte is then biased by the R10 formula, and each chunk must still decrement it. The bench gets there by writing the control byte with a nonzero video mode and the display-enable input low. It then pulses the horizontal-blank input and checks the status byte after the chunk. It also holds the strobe high after a chunk to prove that no second chunk starts. Finally it places the destination at 0x9FF0 so that a chunk crosses the top of the window.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int CHUNK_LOG2 = 4;
  localparam int CNT_FIELD_W = 7;
  localparam int LEN_W = CNT_FIELD_W + CHUNK_LOG2 + 1;

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  function automatic logic [15:0] fold_src(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo[7:4], 4'h0};
  endfunction

  function automatic logic [15:0] fold_dst(input logic [7:0] hi, input logic [7:0] lo);
    return {3'b100, hi[4:0], lo[7:4], 4'h0};
  endfunction

  function automatic logic src_in_vram(input logic [15:0] s);
    return s[15:13] == 3'b100;
  endfunction

  function automatic logic [15:0] dst_step(input logic [15:0] d);
    return {3'b100, d[12:0] + 13'd1};
  endfunction

  function automatic logic [LEN_W-1:0] burst_len(input logic [7:0] v);
    logic [LEN_W-1:0] n;
    n = {{(LEN_W-CNT_FIELD_W){1'b0}}, v[CNT_FIELD_W-1:0]} + 1'b1;
    return n << CHUNK_LOG2;
  endfunction

  function automatic logic [7:0] lcd_off_status(input logic [7:0] v);
    return {1'b1, v[6:0] + 7'd1};
  endfunction
endpackage

// File: rtl/vdma_edge.sv
module vdma_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end
  assign rise = level & ~level_q;
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      start_src,
  input  logic [15:0]      start_dst,
  input  logic [LEN_W-1:0] start_len,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             rd_en,
  output logic [15:0]      rd_addr,
  output logic             wr_en,
  output logic [15:0]      wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic [15:0]      fin_src,
  output logic [15:0]      fin_dst
);
  logic             phase;
  logic [15:0]      cur_src;
  logic [15:0]      cur_dst;
  logic [LEN_W-1:0] left;

  assign rd_en   = busy & ~phase;
  assign rd_addr = cur_src;
  assign wr_en   = busy & phase;
  assign wr_addr = cur_dst;
  assign wr_data = rd_data;
  assign fin_src = cur_src + 16'd1;
  assign fin_dst = dst_step(cur_dst);
  assign done    = wr_en && (left == {{(LEN_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      left    <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      phase   <= 1'b0;
      cur_src <= start_src;
      cur_dst <= start_dst;
      left    <= start_len;
    end else if (busy) begin
      phase <= ~phase;
      if (phase) begin
        cur_src <= fin_src;
        cur_dst <= fin_dst;
        left    <= left - 1'b1;
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic [7:0]       wdata,
  input  logic [2:0]       rsel,
  output logic [7:0]       rdata,
  input  logic [1:0]       video_mode,
  input  logic             lcd_on,
  input  logic             hb_rise,
  input  logic             busy,
  input  logic             done,
  input  logic [15:0]      fin_src,
  input  logic [15:0]      fin_dst,
  output logic             start,
  output logic [15:0]      start_src,
  output logic [15:0]      start_dst,
  output logic [LEN_W-1:0] start_len
);
  logic [7:0] src_hi, src_lo, dst_hi, dst_lo, status;
  logic       hb_mode;
  logic       ctrl_wr, reject, go_now, edge_go;

  assign start_src = fold_src(src_hi, src_lo);
  assign start_dst = fold_dst(dst_hi, dst_lo);
  assign ctrl_wr   = wr && !busy && (sel == SEL_CTRL);
  assign reject    = src_in_vram(start_src);
  assign go_now    = ctrl_wr && !reject &&
                     ((!hb_mode && !wdata[7]) || (video_mode == 2'd0));
  assign edge_go   = hb_mode && hb_rise && !busy && !ctrl_wr;
  assign start     = go_now | edge_go;
  assign start_len = (go_now && !wdata[7]) ? burst_len(wdata)
                                           : LEN_W'(1 << CHUNK_LOG2);

  always_comb begin
    case (rsel)
      SEL_SRC_HI: rdata = src_hi;
      SEL_SRC_LO: rdata = src_lo;
      SEL_DST_HI: rdata = dst_hi;
      SEL_DST_LO: rdata = dst_lo;
      SEL_CTRL:   rdata = status;
      default:    rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi  <= 8'h00;
      src_lo  <= 8'h00;
      dst_hi  <= 8'h00;
      dst_lo  <= 8'h00;
      status  <= 8'hFF;
      hb_mode <= 1'b0;
    end else begin
      if (wr && !busy) begin
        case (sel)
          SEL_SRC_HI: src_hi <= wdata;
          SEL_SRC_LO: src_lo <= wdata;
          SEL_DST_HI: dst_hi <= wdata;
          SEL_DST_LO: dst_lo <= wdata;
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        if (reject) begin
          status <= wdata | 8'h80;
        end else begin
          hb_mode <= wdata[7];
          if (!go_now && wdata[7] && !lcd_on) status <= lcd_off_status(wdata);
          else                                status <= {1'b0, wdata[6:0]};
        end
      end
      if (done) begin
        src_hi <= fin_src[15:8];
        src_lo <= fin_src[7:0];
        dst_hi <= fin_dst[15:8];
        dst_lo <= fin_dst[7:0];
        if (hb_mode) begin
          status <= status - 8'd1;
          if (status == 8'h00) hb_mode <= 1'b0;
        end else begin
          status <= 8'hFF;
        end
      end
    end
  end
endmodule

// File: rtl/vram_dma_ctrl.sv
module vram_dma_ctrl
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  input  logic [2:0]  cfg_rsel,
  output logic [7:0]  cfg_rdata,
  input  logic [1:0]  lcd_mode,
  input  logic        lcd_on,
  input  logic        hblank,
  output logic        mem_rd_en,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr_en,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        cpu_stall
);
  logic             hb_rise;
  logic             burst_start;
  logic             burst_done;
  logic             busy;
  logic [15:0]      start_src, start_dst, fin_src, fin_dst;
  logic [LEN_W-1:0] start_len;

  vdma_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(hblank), .rise(hb_rise)
  );

  vdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .rsel(cfg_rsel), .rdata(cfg_rdata), .video_mode(lcd_mode), .lcd_on(lcd_on),
    .hb_rise(hb_rise), .busy(busy), .done(burst_done), .fin_src(fin_src),
    .fin_dst(fin_dst), .start(burst_start), .start_src(start_src),
    .start_dst(start_dst), .start_len(start_len)
  );

  vdma_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(burst_start), .start_src(start_src),
    .start_dst(start_dst), .start_len(start_len), .rd_data(mem_rd_data),
    .busy(busy), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .wr_en(mem_wr_en),
    .wr_addr(mem_wr_addr), .wr_data(mem_wr_data), .done(burst_done),
    .fin_src(fin_src), .fin_dst(fin_dst)
  );

  assign cpu_stall = busy;
endmodule

// File: rtl/vdma_checker.sv
module vdma_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [3:0] rd_lo,
  input logic       wr_en,
  input logic [2:0] wr_top,
  input logic       stall,
  input logic       burst_start,
  input logic       burst_done
);
  // R6: data is written the cycle after each read
  a_r6_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);
  // R6: reads never come back to back
  a_r6_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  // R6: every write happens with the CPU stalled
  a_r6_wr_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> stall);
  // R3: writes stay inside the video RAM window
  a_r3_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_top == 3'b100));
  // R1: first read of a copy is 16-byte aligned
  a_r1_src_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (rd_en && rd_lo == 4'h0));
  // R6: stall drops right after the last byte
  a_r6_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !stall);
endmodule

bind vram_dma_ctrl vdma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(mem_rd_en), .rd_lo(mem_rd_addr[3:0]),
  .wr_en(mem_wr_en), .wr_top(mem_wr_addr[15:13]), .stall(cpu_stall),
  .burst_start(burst_start), .burst_done(burst_done)
);

// File: tb/sim_vram_dma_ctrl.sv
module sim_vram_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [2:0]  cfg_rsel = 3'd0;
  logic [7:0]  cfg_rdata;
  logic [1:0]  lcd_mode = 2'd2;
  logic        lcd_on = 1'b1;
  logic        hblank = 1'b0;
  logic        mem_rd_en, mem_wr_en, cpu_stall;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data = 8'h00;
  logic [7:0]  mem_wr_data;

  int tests = 0;
  int fails = 0;

  typedef struct packed { logic [15:0] a; logic [7:0] d; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  vram_dma_ctrl u0 (.*);

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pattern(mem_rd_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R9 unexpected write", {mem_wr_addr, mem_wr_data}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk({mem_wr_addr, mem_wr_data} == {e.a, e.d}, "R1/R3/R4 write item",
            {mem_wr_addr, mem_wr_data}, {e.a, e.d});
      end
    end
  end

  task automatic push_burst(input logic [15:0] s, input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({d, pattern(s)});
      s = s + 16'd1;
      d = 16'h8000 | ((d + 16'd1) & 16'h1FFF);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [7:0] v);
    cfg_rsel = sel;
    #0.5;
    v = cfg_rdata;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic hb_pulse(input int hold, output int n, output int extra);
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    count_stall(n);
    extra = 0;
    repeat (hold) begin
      @(negedge clk);
      if (cpu_stall) extra++;
    end
    hblank = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [2:0] sel, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd_reg(sel, v);
    chk(v === e, req, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, x;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    expect_reg(3'd0, 8'h00, "R11 src hi reset");
    expect_reg(3'd1, 8'h00, "R11 src lo reset");
    expect_reg(3'd2, 8'h00, "R11 dst hi reset");
    expect_reg(3'd3, 8'h00, "R11 dst lo reset");
    expect_reg(3'd4, 8'hFF, "R11 status reset");
    chk(cpu_stall == 1'b0, "R11 stall low", cpu_stall, 0);

    // R4 general burst, 48 bytes, masked addresses (R1, R3)
    wr_reg(3'd0, 8'h12); wr_reg(3'd1, 8'h34);
    wr_reg(3'd2, 8'hF5); wr_reg(3'd3, 8'h67);
    push_burst(16'h1230, 16'h9560, 48);
    wr_reg(3'd4, 8'h02);
    count_stall(n);
    chk(n == 96, "R6 stall cycles general", n, 96);
    chk(exp_q.size() == 0, "R4 all bytes written", exp_q.size(), 0);
    expect_reg(3'd4, 8'hFF, "R4 status done");
    expect_reg(3'd0, 8'h12, "R7 src hi writeback");
    expect_reg(3'd1, 8'h60, "R7 src lo writeback");
    expect_reg(3'd2, 8'h95, "R7 dst hi writeback");
    expect_reg(3'd3, 8'h90, "R7 dst lo writeback");

    // R2 source inside video RAM rejected
    wr_reg(3'd0, 8'h88); wr_reg(3'd1, 8'h00);
    wr_reg(3'd4, 8'h05);
    x = 0;
    repeat (10) begin @(negedge clk); if (cpu_stall) x++; end
    chk(x == 0, "R2 no copy on reject", x, 0);
    expect_reg(3'd4, 8'h85, "R2 reject status");

    // R5 armed line-gap mode, R9 one chunk per edge, R3 wrap
    wr_reg(3'd0, 8'h40); wr_reg(3'd1, 8'h00);
    wr_reg(3'd2, 8'h1F); wr_reg(3'd3, 8'hF0);
    lcd_mode = 2'd2; lcd_on = 1'b1;
    wr_reg(3'd4, 8'h81);
    x = 0;
    repeat (6) begin @(negedge clk); if (cpu_stall) x++; end
    chk(x == 0, "R5 armed waits for strobe", x, 0);
    expect_reg(3'd4, 8'h01, "R5 armed status");
    push_burst(16'h4000, 16'h9FF0, 16);
    hb_pulse(40, n, x);
    chk(n == 32, "R9 chunk stall cycles", n, 32);
    chk(x == 0, "R9 held strobe no second chunk", x, 0);
    expect_reg(3'd4, 8'h00, "R8 status decrement");
    expect_reg(3'd2, 8'h80, "R3 dst wrap hi");
    expect_reg(3'd3, 8'h00, "R3 dst wrap lo");
    expect_reg(3'd1, 8'h10, "R7 src lo after chunk");
    push_burst(16'h4010, 16'h8000, 16);
    hb_pulse(4, n, x);
    chk(n == 32, "R9 second chunk", n, 32);
    expect_reg(3'd4, 8'hFF, "R8 status reaches FF");
    hb_pulse(4, n, x);
    chk(n + x == 0, "R8 mode ended no chunk", n + x, 0);

    // R5 line-gap request during video mode 0 starts at once
    wr_reg(3'd0, 8'h20); wr_reg(3'd1, 8'h00);
    wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h40);
    lcd_mode = 2'd0;
    push_burst(16'h2000, 16'h8040, 16);
    wr_reg(3'd4, 8'h80);
    count_stall(n);
    chk(n == 32, "R5 immediate chunk", n, 32);
    expect_reg(3'd4, 8'hFF, "R8 single chunk ends mode");
    hb_pulse(4, n, x);
    chk(n + x == 0, "R8 no chunk after end", n + x, 0);

    // R10 display off biased status, then chunk and cancel
    lcd_mode = 2'd1; lcd_on = 1'b0;
    wr_reg(3'd4, 8'h85);
    expect_reg(3'd4, 8'h86, "R10 display-off status");
    chk(cpu_stall == 1'b0, "R10 no immediate copy", cpu_stall, 0);
    push_burst(16'h2010, 16'h8050, 16);
    hb_pulse(4, n, x);
    chk(n == 32, "R10 chunk while display off", n, 32);
    expect_reg(3'd4, 8'h85, "R8 decrement biased status");
    wr_reg(3'd4, 8'h00);
    expect_reg(3'd4, 8'h00, "R5 cancel status");
    hb_pulse(4, n, x);
    chk(n + x == 0, "R5 cancelled no chunk", n + x, 0);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule